// File: doc/BRIEF.md
# Character LCD Write Controller

This block drives an 8-bit parallel character display module. Out of reset it sends a fixed four-step power-up command sequence. After that it takes single command or data bytes from a valid/ready interface. It can also send a zero-terminated text string, held in a small on-chip ROM, to the start of either display line.

Every write goes through a busy-flag handshake. The controller reads the display's status register and repeats that read while the busy bit is set. Only then does it drive the byte with the matching register-select level and produce the enable pulse that latches it. All enable, setup and hold timings are counted in clock cycles. If the display never reports ready within a configurable number of polls, the pending job is dropped and an error flag is raised.

Top module: `lcdw_ctrl`

## Requirements
- R1: A command byte is written with `lcd_rs` = 0 and a data byte with `lcd_rs` = 1. `lcd_rw` is 0 for every write, and `lcd_doe` is 1 when the enable pulse of a write falls.
- R2: Every enable pulse stays high for exactly `EN_HIGH_CYC` clock cycles. Elaboration rejects any setting shorter than 450 ns. `lcd_rs`, `lcd_rw` and `lcd_dout` are already stable on the cycle the pulse rises and when it falls.
- R3: Each write is preceded by at least one status read (`lcd_rs` = 0, `lcd_rw` = 1). Status reads repeat while bit 7 of `lcd_din` is 1. The write follows the first read that returns bit 7 = 0.
- R4: After reset the block writes the commands 0x38, 0x0C, 0x01 and 0x06, in that order. `in_ready` stays low until the last of them has been written.
- R5: A string request first writes the line-address command: 0x80 when `str_line` = 0, and 0xC0 when `str_line` = 1.
- R6: After the line-address command, a string request writes ROM bytes as data. It starts at `str_base` and stops at the first zero byte, which is not written. The ROM holds "LCD OK" at addresses 0 to 5, "RDY" at 7 to 9, and zero at every other address.
- R7: `lcd_doe` is 0 during every status read.
- R8: If `BUSY_TIMEOUT` status reads in a row return busy, the pending write is dropped with no enable pulse, and the rest of its job is dropped too. `in_ready` then returns high and `err_timeout` is set. `err_timeout` stays set until the next accepted request clears it.
- R9: If `in_valid` and `str_go` are both high on an accepting cycle, only the single byte is written and the string request is ignored.
- R10: `in_ready` is high only when no job is in progress. It goes low on the cycle after an accept, and `lcd_en` is never high while `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Single-byte request valid |
| in_ready | output | 1 | Block idle and able to accept a request |
| in_rs | input | 1 | 0 = command byte, 1 = data byte |
| in_byte | input | 8 | Byte to write |
| str_go | input | 1 | String request, taken while `in_ready` is high |
| str_line | input | 1 | Target line of the string (0 or 1) |
| str_base | input | ROM_AW | ROM address of the first character |
| err_timeout | output | 1 | Busy-poll timeout flag |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display read/write (1 = read) |
| lcd_en | output | 1 | Display enable strobe |
| lcd_dout | output | 8 | Display data bus, outgoing value |
| lcd_doe | output | 1 | Display data bus output enable |
| lcd_din | input | 8 | Display data bus, incoming value |

## Verification
The bench sets the enable width to 113 cycles of a 4 ns clock, the shortest value that meets the 450 ns minimum. It uses one-cycle setup and hold so the tightest timing is checked against the bus model. The busy timeout is set to six polls, so the abandon path and the clearing of the flag afterwards are covered within a few thousand cycles. The display model can keep the busy bit set for a chosen number of reads, which covers multi-poll waits as well as a display that never becomes ready.

// File: rtl/lcdw_pkg.sv
`timescale 1ns/1ps
package lcdw_pkg;

   localparam int unsigned BUSY_BIT  = 7;
   localparam int unsigned INIT_LEN  = 4;
   localparam logic [7:0]  CMD_LINE0 = 8'h80;
   localparam logic [7:0]  CMD_LINE1 = 8'hC0;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_POLL_GO,
      ST_POLL_WAIT,
      ST_WR_GO,
      ST_WR_WAIT,
      ST_NEXT
   } seq_st_t;

   typedef enum logic [1:0] {
      JOB_INIT,
      JOB_ONE,
      JOB_TEXT
   } job_t;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_HIGH,
      PH_HOLD
   } phase_t;

   typedef struct packed {
      logic       rs;
      logic [7:0] val;
   } lcd_word_t;

   // power-up commands, issued in index order
   function automatic logic [7:0] init_cmd(input logic [1:0] idx);
      case (idx)
         2'd0:    return 8'h38;
         2'd1:    return 8'h0C;
         2'd2:    return 8'h01;
         default: return 8'h06;
      endcase
   endfunction

   // text ROM contents, zero everywhere not listed
   function automatic logic [7:0] text_byte(input int unsigned a);
      case (a)
         0:       return 8'h4C;
         1:       return 8'h43;
         2:       return 8'h44;
         3:       return 8'h20;
         4:       return 8'h4F;
         5:       return 8'h4B;
         7:       return 8'h52;
         8:       return 8'h44;
         9:       return 8'h59;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/lcdw_text_rom.sv
`timescale 1ns/1ps
module lcdw_text_rom #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic [AW-1:0] addr,
   output logic [7:0]    rd_val
);

   logic [7:0] mem [DEPTH];

   for (genvar a = 0; a < int'(DEPTH); a++) begin : g_word
      assign mem[a] = lcdw_pkg::text_byte(a);
   end

   assign rd_val = mem[addr];

endmodule

// File: rtl/lcdw_bus_phy.sv
`timescale 1ns/1ps
module lcdw_bus_phy
   import lcdw_pkg::*;
#(
   parameter int unsigned SETUP_CYC   = 2,
   parameter int unsigned EN_HIGH_CYC = 120,
   parameter int unsigned HOLD_CYC    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_go,
   input  logic       op_read,
   input  logic       op_rs,
   input  logic [7:0] op_val,
   output logic       op_done,
   output logic       rd_busy,
   output logic       lcd_rs,
   output logic       lcd_rw,
   output logic       lcd_en,
   output logic [7:0] lcd_dout,
   output logic       lcd_doe,
   input  logic [7:0] lcd_din
);

   localparam int unsigned MAX_SH = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
   localparam int unsigned MAX_C  = (MAX_SH > EN_HIGH_CYC) ? MAX_SH : EN_HIGH_CYC;
   localparam int unsigned CW     = $clog2(MAX_C + 1);
   localparam logic [CW-1:0] SET_LD  = CW'(SETUP_CYC - 1);
   localparam logic [CW-1:0] HIGH_LD = CW'(EN_HIGH_CYC - 1);
   localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC - 1);

   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("SETUP_CYC must be at least 1");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("HOLD_CYC must be at least 1");
   end
   if (EN_HIGH_CYC < 1) begin : g_bad_high
      $error("EN_HIGH_CYC must be at least 1");
   end

   phase_t        ph_q;
   logic [CW-1:0] cnt_q;
   logic          rs_q, rw_q, busy_q;
   logic [7:0]    val_q;
   logic          unused_status_bits;

   assign unused_status_bits = ^lcd_din[6:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         rs_q   <= 1'b0;
         rw_q   <= 1'b0;
         val_q  <= 8'h00;
         busy_q <= 1'b1;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               if (op_go) begin
                  rs_q  <= op_rs;
                  rw_q  <= op_read;
                  val_q <= op_val;
                  cnt_q <= SET_LD;
                  ph_q  <= PH_SETUP;
               end
            end
            PH_SETUP: begin
               if (cnt_q == '0) begin
                  cnt_q <= HIGH_LD;
                  ph_q  <= PH_HIGH;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_HIGH: begin
               if (cnt_q == '0) begin
                  if (rw_q) busy_q <= lcd_din[BUSY_BIT];
                  cnt_q <= HOLD_LD;
                  ph_q  <= PH_HOLD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               if (cnt_q == '0) ph_q <= PH_IDLE;
               else             cnt_q <= cnt_q - 1'b1;
            end
         endcase
      end
   end

   assign op_done  = (ph_q == PH_HOLD) && (cnt_q == '0);
   assign rd_busy  = busy_q;
   assign lcd_rs   = rs_q;
   assign lcd_rw   = rw_q;
   assign lcd_en   = (ph_q == PH_HIGH);
   assign lcd_dout = val_q;
   assign lcd_doe  = (ph_q != PH_IDLE) && !rw_q;

endmodule

// File: rtl/lcdw_seq.sv
`timescale 1ns/1ps
module lcdw_seq
   import lcdw_pkg::*;
#(
   parameter int unsigned ROM_AW        = 5,
   parameter int unsigned TIMEOUT_POLLS = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_rs,
   input  logic [7:0]        in_byte,
   input  logic              str_go,
   input  logic              str_line,
   input  logic [ROM_AW-1:0] str_base,
   output logic [ROM_AW-1:0] rom_addr,
   input  logic [7:0]        rom_val,
   output logic              op_go,
   output logic              op_read,
   output logic              op_rs,
   output logic [7:0]        op_val,
   input  logic              op_done,
   input  logic              rd_busy,
   output logic              err_timeout
);

   localparam int unsigned PW = $clog2(TIMEOUT_POLLS + 1);
   localparam logic [PW-1:0] POLL_LAST = PW'(TIMEOUT_POLLS - 1);
   localparam logic [1:0]    INIT_LAST = 2'(INIT_LEN - 1);

   if (TIMEOUT_POLLS < 1) begin : g_bad_timeout
      $error("TIMEOUT_POLLS must be at least 1");
   end

   seq_st_t           st_q;
   job_t              job_q;
   logic [1:0]        idx_q;
   lcd_word_t         pend_q;
   logic [ROM_AW-1:0] ptr_q;
   logic [PW-1:0]     polls_q;
   logic              err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_POLL_GO;
         job_q   <= JOB_INIT;
         idx_q   <= 2'd0;
         pend_q  <= '{rs: 1'b0, val: init_cmd(2'd0)};
         ptr_q   <= '0;
         polls_q <= '0;
         err_q   <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (in_valid) begin
                  pend_q  <= '{rs: in_rs, val: in_byte};
                  job_q   <= JOB_ONE;
                  polls_q <= '0;
                  err_q   <= 1'b0;
                  st_q    <= ST_POLL_GO;
               end else if (str_go) begin
                  pend_q  <= '{rs: 1'b0, val: (str_line ? CMD_LINE1 : CMD_LINE0)};
                  ptr_q   <= str_base;
                  job_q   <= JOB_TEXT;
                  polls_q <= '0;
                  err_q   <= 1'b0;
                  st_q    <= ST_POLL_GO;
               end
            end
            ST_POLL_GO: st_q <= ST_POLL_WAIT;
            ST_POLL_WAIT: begin
               if (op_done) begin
                  if (!rd_busy) begin
                     st_q <= ST_WR_GO;
                  end else if (polls_q == POLL_LAST) begin
                     err_q <= 1'b1;
                     st_q  <= ST_IDLE;
                  end else begin
                     polls_q <= polls_q + 1'b1;
                     st_q    <= ST_POLL_GO;
                  end
               end
            end
            ST_WR_GO: st_q <= ST_WR_WAIT;
            ST_WR_WAIT: begin
               if (op_done) st_q <= ST_NEXT;
            end
            default: begin
               polls_q <= '0;
               case (job_q)
                  JOB_INIT: begin
                     if (idx_q == INIT_LAST) begin
                        st_q <= ST_IDLE;
                     end else begin
                        idx_q  <= idx_q + 1'b1;
                        pend_q <= '{rs: 1'b0, val: init_cmd(idx_q + 1'b1)};
                        st_q   <= ST_POLL_GO;
                     end
                  end
                  JOB_TEXT: begin
                     if (rom_val == 8'h00) begin
                        st_q <= ST_IDLE;
                     end else begin
                        pend_q <= '{rs: 1'b1, val: rom_val};
                        ptr_q  <= ptr_q + 1'b1;
                        st_q   <= ST_POLL_GO;
                     end
                  end
                  default: st_q <= ST_IDLE;
               endcase
            end
         endcase
      end
   end

   assign in_ready    = (st_q == ST_IDLE);
   assign rom_addr    = ptr_q;
   assign op_go       = (st_q == ST_POLL_GO) || (st_q == ST_WR_GO);
   assign op_read     = (st_q == ST_POLL_GO);
   assign op_rs       = op_read ? 1'b0 : pend_q.rs;
   assign op_val      = pend_q.val;
   assign err_timeout = err_q;

endmodule

// File: rtl/lcdw_ctrl.sv
`timescale 1ns/1ps
module lcdw_ctrl #(
   parameter int unsigned CLK_PERIOD_PS = 4000,
   parameter int unsigned EN_HIGH_CYC   = 120,
   parameter int unsigned SETUP_CYC     = 2,
   parameter int unsigned HOLD_CYC      = 2,
   parameter int unsigned ROM_DEPTH     = 32,
   parameter int unsigned BUSY_TIMEOUT  = 1000,
   localparam int unsigned ROM_AW       = $clog2(ROM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_rs,
   input  logic [7:0]        in_byte,
   input  logic              str_go,
   input  logic              str_line,
   input  logic [ROM_AW-1:0] str_base,
   output logic              err_timeout,
   output logic              lcd_rs,
   output logic              lcd_rw,
   output logic              lcd_en,
   output logic [7:0]        lcd_dout,
   output logic              lcd_doe,
   input  logic [7:0]        lcd_din
);

   localparam longint unsigned EN_MIN_PS = 450000;

   if (longint'(EN_HIGH_CYC) * longint'(CLK_PERIOD_PS) < EN_MIN_PS) begin : g_en_short
      $error("enable pulse shorter than 450 ns");
   end
   if ((ROM_DEPTH < 2) || (ROM_DEPTH > 256) || ((ROM_DEPTH & (ROM_DEPTH - 1)) != 0)) begin : g_bad_rom
      $error("ROM_DEPTH must be a power of two from 2 to 256");
   end

   logic [ROM_AW-1:0] rom_addr;
   logic [7:0]        rom_val;
   logic              op_go, op_read, op_rs, op_done, rd_busy;
   logic [7:0]        op_val;

   lcdw_text_rom #(.DEPTH(ROM_DEPTH), .AW(ROM_AW)) u_rom (
      .addr   (rom_addr),
      .rd_val (rom_val)
   );

   lcdw_seq #(.ROM_AW(ROM_AW), .TIMEOUT_POLLS(BUSY_TIMEOUT)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_rs       (in_rs),
      .in_byte     (in_byte),
      .str_go      (str_go),
      .str_line    (str_line),
      .str_base    (str_base),
      .rom_addr    (rom_addr),
      .rom_val     (rom_val),
      .op_go       (op_go),
      .op_read     (op_read),
      .op_rs       (op_rs),
      .op_val      (op_val),
      .op_done     (op_done),
      .rd_busy     (rd_busy),
      .err_timeout (err_timeout)
   );

   lcdw_bus_phy #(
      .SETUP_CYC   (SETUP_CYC),
      .EN_HIGH_CYC (EN_HIGH_CYC),
      .HOLD_CYC    (HOLD_CYC)
   ) u_phy (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_go    (op_go),
      .op_read  (op_read),
      .op_rs    (op_rs),
      .op_val   (op_val),
      .op_done  (op_done),
      .rd_busy  (rd_busy),
      .lcd_rs   (lcd_rs),
      .lcd_rw   (lcd_rw),
      .lcd_en   (lcd_en),
      .lcd_dout (lcd_dout),
      .lcd_doe  (lcd_doe),
      .lcd_din  (lcd_din)
   );

endmodule

// File: rtl/lcdw_ctrl_chk.sv
`timescale 1ns/1ps
module lcdw_ctrl_chk #(
   parameter int unsigned EN_HIGH_CYC = 120
) (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       str_go,
   input logic       in_ready,
   input logic       err_timeout,
   input logic       lcd_rs,
   input logic       lcd_rw,
   input logic       lcd_en,
   input logic [7:0] lcd_dout,
   input logic       lcd_doe,
   input logic [7:0] lcd_din
);

   localparam int unsigned EW = $clog2(EN_HIGH_CYC + 2) + 1;

   logic [EW-1:0] en_cnt_q;
   logic          en_q, last_busy_q, ready_seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_cnt_q     <= '0;
         en_q         <= 1'b0;
         last_busy_q  <= 1'b1;
         ready_seen_q <= 1'b0;
      end else begin
         en_q     <= lcd_en;
         en_cnt_q <= lcd_en ? en_cnt_q + 1'b1 : '0;
         if (lcd_en && lcd_rw) last_busy_q <= lcd_din[7];
         if (en_q && !lcd_en) ready_seen_q <= lcd_rw ? !last_busy_q : 1'b0;
      end
   end

   a_r2_en_width: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !lcd_en) |-> (en_cnt_q == EW'(EN_HIGH_CYC)));

   a_r2_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_en) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_dout)));

   a_r2_fall_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_en) |-> ($stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_dout)));

   a_r1_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !lcd_en && !lcd_rw) |-> lcd_doe);

   a_r3_poll_before_write: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !lcd_en && !lcd_rw) |-> ready_seen_q);

   a_r7_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (lcd_en && lcd_rw) |-> !lcd_doe);

   a_r8_err_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_timeout) |-> in_ready);

   a_r8_err_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_timeout) |-> $past(in_ready && (in_valid || str_go)));

   a_r10_quiet_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !lcd_en);

endmodule

bind lcdw_ctrl lcdw_ctrl_chk #(.EN_HIGH_CYC(EN_HIGH_CYC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .str_go      (str_go),
   .in_ready    (in_ready),
   .err_timeout (err_timeout),
   .lcd_rs      (lcd_rs),
   .lcd_rw      (lcd_rw),
   .lcd_en      (lcd_en),
   .lcd_dout    (lcd_dout),
   .lcd_doe     (lcd_doe),
   .lcd_din     (lcd_din)
);

// File: tb/lcdw_ctrl_bench.sv
`timescale 1ns/1ps
module lcdw_ctrl_bench;

   localparam int EN_CYC  = 113;
   localparam int TIMEOUT = 6;
   localparam int AW      = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid, in_rs, str_go, str_line;
   logic [7:0]    in_byte;
   logic [AW-1:0] str_base;
   logic          in_ready, err_timeout;
   logic          lcd_rs, lcd_rw, lcd_en, lcd_doe;
   logic [7:0]    lcd_dout, lcd_din;

   lcdw_ctrl #(
      .CLK_PERIOD_PS (4000),
      .EN_HIGH_CYC   (EN_CYC),
      .SETUP_CYC     (1),
      .HOLD_CYC      (1),
      .ROM_DEPTH     (32),
      .BUSY_TIMEOUT  (TIMEOUT)
   ) u_lcdw_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_rs(in_rs), .in_byte(in_byte), .str_go(str_go), .str_line(str_line),
      .str_base(str_base), .err_timeout(err_timeout), .lcd_rs(lcd_rs),
      .lcd_rw(lcd_rw), .lcd_en(lcd_en), .lcd_dout(lcd_dout), .lcd_doe(lcd_doe),
      .lcd_din(lcd_din)
   );

   always #2 clk = ~clk;

   int   checks = 0, errors = 0;
   int   write_count = 0, reads_since_write = 0, last_reads = 0;
   int   busy_left = 0, high_cnt = 0;
   bit   prev_en = 1'b0, finished = 1'b0;
   logic [8:0] exp_q[$];

   assign lcd_din = {(busy_left != 0), 7'd0};

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] model_rom(input int a);
      string s0 = "LCD OK";
      string s1 = "RDY";
      if (a < 6) return s0[a];
      if (a >= 7 && a < 10) return s1[a-7];
      return 8'h00;
   endfunction

   // monitor: display bus model and scoreboard
   always @(negedge clk) begin
      if (lcd_en) begin
         high_cnt++;
      end else if (prev_en) begin
         if (lcd_rw) begin
            reads_since_write++;
            chk(!lcd_doe, "R7", "bus driven during status read", lcd_doe, 0);
            if (busy_left > 0) busy_left--;
         end else begin
            chk(lcd_doe, "R1", "bus not driven at write latch", lcd_doe, 1);
            chk(high_cnt == EN_CYC, "R2", "enable width", high_cnt, EN_CYC);
            chk(reads_since_write >= 1, "R3", "write without status read", reads_since_write, 1);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9", "unexpected write", {lcd_rs, lcd_dout}, 0);
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               chk({lcd_rs, lcd_dout} == e, "R1 R4 R5 R6", "written rs/byte", {lcd_rs, lcd_dout}, e);
            end
            write_count++;
            last_reads = reads_since_write;
            reads_since_write = 0;
         end
         high_cnt = 0;
      end
      prev_en = lcd_en;
   end

   task automatic wait_idle();
      do @(negedge clk); while (!in_ready);
   endtask

   task automatic send(input logic rs, input logic [7:0] val, input bit expect_it);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_rs = rs; in_byte = val;
      if (expect_it) exp_q.push_back({rs, val});
      @(negedge clk);
      in_valid = 1'b0;
      chk(!in_ready, "R10", "ready after accept", in_ready, 0);
   endtask

   task automatic text(input logic line, input int base);
      while (!in_ready) @(negedge clk);
      str_go = 1'b1; str_line = line; str_base = AW'(base);
      exp_q.push_back({1'b0, (line ? 8'hC0 : 8'h80)});
      for (int a = base; model_rom(a) != 8'h00; a++) exp_q.push_back({1'b1, model_rom(a)});
      @(negedge clk);
      str_go = 1'b0;
   endtask

   initial begin
      int wc0;
      rst_n = 1'b0; in_valid = 1'b0; in_rs = 1'b0; in_byte = 8'h00;
      str_go = 1'b0; str_line = 1'b0; str_base = '0;
      repeat (3) @(negedge clk);
      chk(lcd_en == 1'b0, "R10", "enable in reset", lcd_en, 0);
      chk(lcd_doe == 1'b0, "R7", "bus drive in reset", lcd_doe, 0);
      chk(in_ready == 1'b0, "R4", "ready in reset", in_ready, 0);
      exp_q.push_back({1'b0, 8'h38});
      exp_q.push_back({1'b0, 8'h0C});
      exp_q.push_back({1'b0, 8'h01});
      exp_q.push_back({1'b0, 8'h06});
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(in_ready == 1'b0, "R4", "ready during init", in_ready, 0);
      wait_idle();
      chk(write_count == 4, "R4", "init write count", write_count, 4);
      chk(exp_q.size() == 0, "R4", "init items left", exp_q.size(), 0);

      // R1: command then data
      send(1'b0, 8'h14, 1'b1);
      wait_idle();
      send(1'b1, 8'h41, 1'b1);
      wait_idle();

      // R3: busy held for three reads
      busy_left = 3;
      send(1'b1, 8'h42, 1'b1);
      wait_idle();
      chk(last_reads == 4, "R3", "status reads before write", last_reads, 4);

      // R5 R6: strings on both lines
      text(1'b0, 0);
      wait_idle();
      text(1'b1, 7);
      wait_idle();
      chk(exp_q.size() == 0, "R6", "string items left", exp_q.size(), 0);

      // R6: empty string writes only the address command
      wc0 = write_count;
      text(1'b0, 11);
      wait_idle();
      chk(write_count == wc0 + 1, "R6", "empty string writes", write_count - wc0, 1);

      // R8: display stuck busy
      wc0 = write_count;
      busy_left = 100000;
      send(1'b1, 8'h5A, 1'b0);
      wait_idle();
      chk(err_timeout == 1'b1, "R8", "timeout flag", err_timeout, 1);
      chk(write_count == wc0, "R8", "write after timeout", write_count - wc0, 0);
      chk(reads_since_write == TIMEOUT, "R8", "polls before abandon", reads_since_write, TIMEOUT);
      busy_left = 0;
      reads_since_write = 0;
      send(1'b1, 8'h59, 1'b1);
      chk(err_timeout == 1'b0, "R8", "flag cleared on accept", err_timeout, 0);
      wait_idle();

      // R9: simultaneous requests
      wc0 = write_count;
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_rs = 1'b1; in_byte = 8'h50;
      str_go = 1'b1; str_line = 1'b1; str_base = '0;
      exp_q.push_back({1'b1, 8'h50});
      @(negedge clk);
      in_valid = 1'b0; str_go = 1'b0;
      wait_idle();
      repeat (600) @(negedge clk);
      chk(write_count == wc0 + 1, "R9", "writes for combined request", write_count - wc0, 1);
      chk(in_ready == 1'b1, "R10", "ready when done", in_ready, 1);
      chk(exp_q.size() == 0, "R9", "scoreboard items left", exp_q.size(), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule